// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

A general-purpose I/O block for up to 64 pins. Each pin has its own direction bit and output value. It also has an interrupt path with its own enable, trigger type and polarity. The type bit selects level or edge detection. The polarity bit selects high or rising, or low or falling, so together they give four trigger modes. Pin inputs pass through a two-flop synchroniser. Detected events are latched in a per-pin status bit, which software clears by writing 1 to it. Each status bit, masked by its enable, feeds a single registered interrupt line.

Every feature is split into 32-bit banks. Pin n lives at bit n mod 32 of the word at the feature's base offset plus 4*(n div 32). A single-cycle write strobe with an address and data reaches all the registers. Reads are combinational from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Byte offsets are: direction 0x00/0x04, output value 0x08/0x0C, interrupt enable 0x18/0x1C, polarity 0x38/0x3C, type 0x40/0x44, status 0x48/0x4C. The first offset of each pair holds pins 0-31 and the second holds pins 32-63. Pin n is bit n mod 32.
- R2: A direction bit of 1 makes `pin_oe` high for that pin. `pin_out` carries the output-value register. Neither output changes unless a write occurs.
- R3: With type 0, a pin is level-triggered: polarity 0 triggers on a high input and polarity 1 on a low input. The status bit is set on every cycle the synchronised input is at the active level, three clock edges after the input changes.
- R4: With type 1, a pin is edge-triggered: polarity 0 triggers on a rising edge and polarity 1 on a falling edge. The synchronised value is compared with its previous sample, and the opposite edge sets nothing.
- R5: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A level-triggered bit whose level is still present stays set. Without a write, no status bit ever falls.
- R6: When a trigger and a write-1-to-clear hit the same pin in the same cycle, the status bit ends up set.
- R7: `irq` is a register loaded every cycle with the OR over pins of (status AND enable). Clearing an enable removes that pin's contribution on the following edge, while its status bit is kept.
- R8: Reads of unmapped or misaligned offsets, or offsets at or above 0x100, return zero. Register bits for pins at or above NPINS read as zero and ignore writes.
- R9: Synchronous active-low reset clears every register, the synchroniser and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses a 40-pin build, so the upper bank is only partly populated. Directed patterns cover each case separately:
- A held high level and a held low level show level mode re-setting status after a clear.
- A single rising pulse and a single falling pulse show edge mode latching once and ignoring the opposite edge.
- An edge timed to land on the same edge as its clear separates the two possible priorities.
- Enabling and then disabling a pin with latched status separates the status latch from the interrupt gate.

A long random phase then toggles pins and writes random data to mapped, unmapped and misaligned offsets. It compares every read word and output against a behavioural model on each clock.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPINS = 64,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic             irq
);
  localparam logic [63:0] PMASK = (NPINS >= 64) ? {64{1'b1}} : ((64'd1 << NPINS) - 64'd1);
  localparam logic [4:0] G_DIR = 5'd0, G_VAL = 5'd1, G_IEN = 5'd3,
                         G_POL = 5'd7, G_TYP = 5'd8, G_STS = 5'd9;

  logic [63:0] oe_q, drv_q, ie_q, pol_q, typ_q, stat_q;
  logic [63:0] s1_q, s2_q, prev_q;
  logic [63:0] in64, bmask, wr64, lvl, edg, hit, clr, sel;
  logic [4:0]  grp;
  logic        in_win;

  assign grp    = addr[7:3];
  assign in_win = ((addr >> 8) == '0) && (addr[1:0] == 2'b00);
  assign bmask  = addr[2] ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
  assign wr64   = {wdata, wdata} & bmask & PMASK;

  always_comb begin
    in64 = '0;
    in64[NPINS-1:0] = pin_in;
  end

  assign lvl = s2_q ^ pol_q;
  assign edg = (s2_q & ~prev_q & ~pol_q) | (prev_q & ~s2_q & pol_q);
  assign hit = ((typ_q & edg) | (~typ_q & lvl)) & PMASK;
  assign clr = (wr_en && in_win && grp == G_STS) ? wr64 : '0;

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] bm,
                                        input logic [63:0] nv);
    return (old & ~bm) | nv;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q <= '0; drv_q <= '0; ie_q <= '0; pol_q <= '0; typ_q <= '0; stat_q <= '0;
      s1_q <= '0; s2_q <= '0; prev_q <= '0; irq <= 1'b0;
    end else begin
      s1_q   <= in64 & PMASK;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      stat_q <= (stat_q & ~clr) | hit;
      irq    <= |(stat_q & ie_q);
      if (wr_en && in_win) begin
        case (grp)
          G_DIR: oe_q  <= merge(oe_q,  bmask, wr64);
          G_VAL: drv_q <= merge(drv_q, bmask, wr64);
          G_IEN: ie_q  <= merge(ie_q,  bmask, wr64);
          G_POL: pol_q <= merge(pol_q, bmask, wr64);
          G_TYP: typ_q <= merge(typ_q, bmask, wr64);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (grp)
      G_DIR:   sel = oe_q;
      G_VAL:   sel = drv_q;
      G_IEN:   sel = ie_q;
      G_POL:   sel = pol_q;
      G_TYP:   sel = typ_q;
      G_STS:   sel = stat_q;
      default: sel = '0;
    endcase
    rdata = !in_win ? 32'h0 : (addr[2] ? sel[63:32] : sel[31:0]);
  end

  assign pin_oe  = oe_q[NPINS-1:0];
  assign pin_out = drv_q[NPINS-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [63:0]      stat,
  input logic [63:0]      ie,
  input logic             irq,
  input logic [NPINS-1:0] pin_oe
);
  localparam logic [63:0] VMASK = (NPINS >= 64) ? {64{1'b1}} : ((64'd1 << NPINS) - 64'd1);

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n) (|(stat & ie)) |=> irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) !(|(stat & ie)) |=> !irq); // R7
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> ((stat & $past(stat)) == $past(stat))); // R5
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(pin_oe)); // R2

  always @(posedge clk) begin
    if (rst_n) begin
      AST_UPPER_CLEAR: assert ((stat & ~VMASK) == 64'h0); // R8
    end
  end
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stat(stat_q), .ie(ie_q), .irq(irq), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NP = 40;
  localparam logic [63:0] PM = 64'h0000_00FF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out;
  logic irq;

  int checks = 0, errors = 0;
  bit cmp_on = 0, finished = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  logic [63:0] m_oe, m_dv, m_ie, m_po, m_ty, m_st, m_a, m_b, m_c;
  logic m_irq;

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_oe[31:0];  8'h04: return m_oe[63:32];
      8'h08: return m_dv[31:0];  8'h0C: return m_dv[63:32];
      8'h18: return m_ie[31:0];  8'h1C: return m_ie[63:32];
      8'h38: return m_po[31:0];  8'h3C: return m_po[63:32];
      8'h40: return m_ty[31:0];  8'h44: return m_ty[63:32];
      8'h48: return m_st[31:0];  8'h4C: return m_st[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oe = 0; m_dv = 0; m_ie = 0; m_po = 0; m_ty = 0; m_st = 0;
      m_a = 0; m_b = 0; m_c = 0; m_irq = 0;
    end else begin
      logic [63:0] nst, w;
      m_irq = |(m_st & m_ie);
      for (int i = 0; i < 64; i++) begin
        bit trig;
        if (m_ty[i]) trig = m_po[i] ? (m_c[i] && !m_b[i]) : (!m_c[i] && m_b[i]);
        else         trig = m_po[i] ? !m_b[i] : m_b[i];
        if (i >= NP) trig = 0;
        nst[i] = trig ? 1'b1 : m_st[i];
      end
      w = {wdata, wdata} & PM;
      if (wr_en) begin
        case (addr)
          8'h00: m_oe[31:0] = w[31:0];  8'h04: m_oe[63:32] = w[63:32];
          8'h08: m_dv[31:0] = w[31:0];  8'h0C: m_dv[63:32] = w[63:32];
          8'h18: m_ie[31:0] = w[31:0];  8'h1C: m_ie[63:32] = w[63:32];
          8'h38: m_po[31:0] = w[31:0];  8'h3C: m_po[63:32] = w[63:32];
          8'h40: m_ty[31:0] = w[31:0];  8'h44: m_ty[63:32] = w[63:32];
          8'h48: for (int i = 0; i < 32; i++) if (w[i] && !(nst[i] && !m_st[i]) && !trig_now(i)) nst[i] = 0;
          8'h4C: for (int i = 32; i < 64; i++) if (w[i] && !trig_now(i)) nst[i] = 0;
          default: ;
        endcase
      end
      m_st = nst;
      m_c = m_b; m_b = m_a; m_a = {24'h0, pin_in};
    end
  end

  function automatic bit trig_now(input int i);
    if (i >= NP) return 0;
    if (m_ty[i]) return m_po[i] ? (m_c[i] && !m_b[i]) : (!m_c[i] && m_b[i]);
    return m_po[i] ? !m_b[i] : m_b[i];
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (cmp_on) begin
      chk(64'(rdata), 64'(m_rd(addr)), "R1 read data vs model");
      chk(64'(pin_oe), m_oe & PM, "R2 pin_oe vs model");
      chk(64'(pin_out), m_dv & PM, "R2 pin_out vs model");
      chk(64'(irq), 64'(m_irq), "R7 irq vs model");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; wr_en = 1'b0;
    #4 chk(64'(rdata), 64'(exp), tag);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h38,
                               8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h10, 8'h4A};
    wait_n(3);
    rst_n = 1'b1;
    cmp_on = 1;
    // R9 reset state
    foreach (alist[k]) rd(alist[k], 32'h0, "R9 register zero after reset");
    chk(64'(irq), 64'h0, "R9 irq low after reset");
    // R1 / R8 / R2 mapping and masking
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_FFFF, "R1 direction low bank");
    rd(8'h04, 32'h0000_00FF, "R8 upper pins masked");
    chk(64'(pin_oe), PM, "R2 all pins output");
    wr(8'h08, 32'hA5A5_0F0F); wr(8'h0C, 32'h1234_5678);
    chk(64'(pin_out), 64'h78_A5A5_0F0F, "R1 value banks map to pins");
    rd(8'h0C, 32'h0000_0078, "R8 value upper bits masked");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R8 unmapped offset reads zero");
    rd(8'h50, 32'h0, "R8 offset past map reads zero");
    rd(8'h01, 32'h0, "R8 misaligned reads zero");
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    chk(64'(pin_oe), 64'h0, "R2 all pins input");
    // R3 level high, pin 3
    pin_in[3] = 1'b1; wait_n(4);
    rd(8'h48, 32'h8, "R3 level-high latched");
    chk(64'(irq), 64'h0, "R7 disabled pin no irq");
    wr(8'h18, 32'h8); @(negedge clk);
    chk(64'(irq), 64'h1, "R7 enabled pin raises irq");
    wr(8'h48, 32'h8); wait_n(2);
    rd(8'h48, 32'h8, "R5 level present re-sets status");
    pin_in[3] = 1'b0; wait_n(4);
    wr(8'h48, 32'h0);
    rd(8'h48, 32'h8, "R5 write zero keeps status");
    wr(8'h48, 32'h8);
    rd(8'h48, 32'h0, "R5 write one clears status");
    @(negedge clk);
    chk(64'(irq), 64'h0, "R7 irq drops after clear");
    // R3 level low, pin 33
    wr(8'h3C, 32'h2); wait_n(3);
    rd(8'h4C, 32'h2, "R3 level-low latched");
    pin_in[33] = 1'b1; wait_n(4);
    wr(8'h4C, 32'h2);
    rd(8'h4C, 32'h0, "R3 level-low cleared once high");
    // R4 rising edge, pin 5
    wr(8'h40, 32'h20);
    pin_in[5] = 1'b1; wait_n(4);
    rd(8'h48, 32'h20, "R4 rising edge latched");
    wr(8'h48, 32'h20);
    rd(8'h48, 32'h0, "R4 edge does not re-set while high");
    // R4 falling edge, pin 38
    wr(8'h44, 32'h40); wr(8'h3C, 32'h42);
    pin_in[38] = 1'b1; wait_n(4);
    rd(8'h4C, 32'h0, "R4 rise ignored in falling mode");
    pin_in[38] = 1'b0; wait_n(4);
    rd(8'h4C, 32'h40, "R4 falling edge latched");
    wr(8'h4C, 32'h40);
    // R6 set wins over clear, pin 5
    pin_in[5] = 1'b0; wait_n(3);
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    wr(8'h48, 32'h20);
    rd(8'h48, 32'h20, "R6 edge wins over same-cycle clear");
    wr(8'h48, 32'h20);
    rd(8'h48, 32'h0, "R5 clear after collision");
    // R7 enable gating, pin 3
    pin_in[3] = 1'b1; wait_n(5);
    chk(64'(irq), 64'h1, "R7 irq with enable");
    wr(8'h18, 32'h0); @(negedge clk);
    chk(64'(irq), 64'h0, "R7 irq gone after disable");
    rd(8'h48, 32'h8, "R7 status kept after disable");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pin_in = NP'({$urandom, $urandom}) ^ pin_in & NP'({$urandom, $urandom});
      addr = alist[$urandom % 14];
      wr_en = ($urandom % 4) == 0;
      wdata = $urandom;
    end
    @(negedge clk); wr_en = 1'b0;
    wait_n(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule